// File: doc/BRIEF.md
# Two-Bank Interrupt Status Controller

This block gathers single-cycle event pulses from two producers, a hash engine and the DMA engine that feeds it. Each pulse is latched into a sticky status bit. Each producer has its own status register and its own enable register. The controller combines the enabled pending bits into one interrupt line. The DMA bank also passes through a one-bit gate register before it can reach that line.

A second output, an error summary, goes high whenever any enabled error cause is pending in either bank. The gate register does not affect this output.

Software works through a plain 32-bit register port: a write strobe, an address, write data, and a combinational read data bus. A typical interrupt handler reads a status register and writes the same value back to acknowledge it. Status bits are write-one-to-clear. An event that arrives in the same cycle as its own clear is never lost.

Top module: `irq_status_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all five registers read 0 and both `irq` and `irq_err` are low.
- R2: A pulse on `hash_evt[i]` sets hash status bit i, which is read at offset 0x00, on the next clock. The bit then stays set until it is cleared. Bit 2 is the hash done cause; bits 0, 1 and 3 are hash error causes; bits 31:4 read 0.
- R3: A pulse on `dma_evt[i]` sets DMA status bit i, which is read at offset 0x10, on the next clock. Bit 0 is the transfer done cause and bits 2 to 8 are DMA error causes. Bit 1 is not implemented: a pulse on it leaves status bit 1 at 0. Bits 31:9 read 0.
- R4: Writing a status register clears exactly the bits written as 1 and leaves the bits written as 0 unchanged. Writing all ones clears every pending bit in that bank.
- R5: If an event pulse and a clear of the same bit occur in the same cycle, the bit is set after that clock.
- R6: The hash enable register at 0x04 and the DMA enable register at 0x14 store the implemented bits written to them. The DMA gate at 0x18 stores bit 0. Writing 0 to an enable register keeps that bank off the interrupt line.
- R7: `irq` is high exactly when (hash status AND hash enable) is nonzero, or when (DMA status AND DMA enable) is nonzero and gate bit 0 is 1.
- R8: `irq_err` is high exactly when an enabled error bit is pending in either bank. For the hash bank these are bits 0, 1 and 3; for the DMA bank they are bits 2 to 8. The gate does not affect `irq_err`.
- R9: Reads of any unmapped address return 0, and writes to an unmapped address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| hash_evt | input | 4 | Hash engine event pulses |
| dma_evt | input | 9 | DMA event pulses |
| irq | output | 1 | Combined interrupt request |
| irq_err | output | 1 | Enabled error pending in either bank |

## Verification
The random phase drives event pulses into both banks together with random writes: all-ones and partial status clears, enable and gate changes, and writes to unmapped addresses. This stimulus separates a correct write-one-to-clear from a full clear and from a clear that ignores the mask. It also shows whether the gate acts only on the DMA bank.

Directed cases cover the rest:
- a pulse that collides with a clear of the same bit, which shows whether the event wins;
- the unimplemented DMA bit 1;
- a bank whose enable register is zero;
- the error summary with the gate closed, which tells the done causes apart from the error causes.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int HASH_W = 4;
    localparam int DMA_W  = 9;

    // Implemented bits, plus done and error groupings, for each bank
    localparam logic [HASH_W-1:0] HASH_IMPL = 4'b1111;
    localparam logic [HASH_W-1:0] HASH_ERRS = 4'b1011;
    localparam logic [DMA_W-1:0]  DMA_IMPL  = 9'h1FD;
    localparam logic [DMA_W-1:0]  DMA_ERRS  = 9'h1FC;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFS_HASH_STS = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_HASH_EN  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_DMA_STS  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_DMA_EN   = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_DMA_GATE = 12'h018;
endpackage

// File: rtl/sticky_bank.sv
// sticky_bank: one bank made of a sticky status register and its enable register.
// Assumes: event inputs are single-cycle pulses; clr_we/en_we come from an
// address decode and are never high together. Bits outside IMPL are tied to 0.
module sticky_bank #(
    parameter int W = 4,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] enable
);
    logic [W-1:0] clr_bits;

    // Select the bits cleared this cycle
    always_comb clr_bits = clr_we ? wdata : '0;

    // Status update: clear the written ones, then OR in new events so an event wins
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= ((status & ~clr_bits) | evt) & IMPL;
    end

    // Enable register: stores the implemented bits on a write
    always_ff @(posedge clk) begin
        if (!rst_n)     enable <= '0;
        else if (en_we) enable <= wdata & IMPL;
    end

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & IMPL)) |=> ((status & $past(evt & IMPL)) == $past(evt & IMPL)));
    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && (|(evt & wdata & IMPL))) |=>
        ((status & $past(evt & wdata & IMPL)) != '0));
    assert_clear_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && evt == '0) |=> ((status & $past(wdata)) == '0));
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we) |=> ((status & $past(status)) == $past(status)));
    assert_enable_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> (enable == $past(wdata & IMPL)));
endmodule

// File: rtl/irq_merge.sv
// irq_merge: merges the enabled pending bits of both banks into two outputs.
// Assumes: the gate acts only on the interrupt line, never on the error summary.
module irq_merge #(
    parameter int HW = 4,
    parameter int DW = 9,
    parameter logic [HW-1:0] H_ERR = '1,
    parameter logic [DW-1:0] D_ERR = '1
) (
    input  logic [HW-1:0] h_sts,
    input  logic [HW-1:0] h_en,
    input  logic [DW-1:0] d_sts,
    input  logic [DW-1:0] d_en,
    input  logic          d_gate,
    output logic          irq,
    output logic          irq_err
);
    logic [HW-1:0] h_act;
    logic [DW-1:0] d_act;

    // Pending and enabled causes for each bank
    always_comb begin
        h_act = h_sts & h_en;
        d_act = d_sts & d_en;
    end

    // Output combine: the DMA bank passes through its gate
    always_comb begin
        irq     = (|h_act) | ((|d_act) & d_gate);
        irq_err = (|(h_act & H_ERR)) | (|(d_act & D_ERR));
    end
endmodule

// File: rtl/irq_status_ctrl.sv
// irq_status_ctrl: top level. Decodes register writes into the two banks and
// the DMA gate, multiplexes read data, and merges the interrupt outputs.
// Assumes: a single-cycle write strobe and a combinational read.
module irq_status_ctrl
    import irq_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [HASH_W-1:0] hash_evt,
    input  logic [DMA_W-1:0]  dma_evt,
    output logic              irq,
    output logic              irq_err
);
    logic [HASH_W-1:0] h_sts, h_en;
    logic [DMA_W-1:0]  d_sts, d_en;
    logic              d_gate;
    logic              we_hs, we_he, we_ds, we_de, we_dg;

    // Address decode for writes
    always_comb begin
        we_hs = reg_we && (reg_addr == OFS_HASH_STS);
        we_he = reg_we && (reg_addr == OFS_HASH_EN);
        we_ds = reg_we && (reg_addr == OFS_DMA_STS);
        we_de = reg_we && (reg_addr == OFS_DMA_EN);
        we_dg = reg_we && (reg_addr == OFS_DMA_GATE);
    end

    sticky_bank #(.W(HASH_W), .IMPL(HASH_IMPL)) u_hash (
        .clk(clk), .rst_n(rst_n), .evt(hash_evt), .clr_we(we_hs), .en_we(we_he),
        .wdata(reg_wdata[HASH_W-1:0]), .status(h_sts), .enable(h_en)
    );

    sticky_bank #(.W(DMA_W), .IMPL(DMA_IMPL)) u_dma (
        .clk(clk), .rst_n(rst_n), .evt(dma_evt), .clr_we(we_ds), .en_we(we_de),
        .wdata(reg_wdata[DMA_W-1:0]), .status(d_sts), .enable(d_en)
    );

    // DMA gate register: a single stored bit
    always_ff @(posedge clk) begin
        if (!rst_n)     d_gate <= 1'b0;
        else if (we_dg) d_gate <= reg_wdata[0];
    end

    // Read multiplexer; unmapped addresses return zero
    always_comb begin
        case (reg_addr)
            OFS_HASH_STS: reg_rdata = DATA_W'(h_sts);
            OFS_HASH_EN:  reg_rdata = DATA_W'(h_en);
            OFS_DMA_STS:  reg_rdata = DATA_W'(d_sts);
            OFS_DMA_EN:   reg_rdata = DATA_W'(d_en);
            OFS_DMA_GATE: reg_rdata = DATA_W'(d_gate);
            default:      reg_rdata = '0;
        endcase
    end

    irq_merge #(.HW(HASH_W), .DW(DMA_W), .H_ERR(HASH_ERRS), .D_ERR(DMA_ERRS)) u_merge (
        .h_sts(h_sts), .h_en(h_en), .d_sts(d_sts), .d_en(d_en), .d_gate(d_gate),
        .irq(irq), .irq_err(irq_err)
    );

    assert_gate_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_gate && (h_sts & h_en) == '0) |-> !irq);
    assert_zero_enable_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_en == '0 && d_en == '0) |-> (!irq && !irq_err));
    assert_dma_bit1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_evt[1] |=> !d_sts[1]);
    assert_err_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> irq || !d_gate);
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  hash_evt = '0;
    logic [8:0]  dma_evt = '0;
    logic        irq, irq_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference register state, kept from the requirements
    logic [3:0] m_hs, m_he;
    logic [8:0] m_ds, m_de;
    logic       m_g;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hash_evt(hash_evt),
        .dma_evt(dma_evt), .irq(irq), .irq_err(irq_err)
    );

    function automatic logic exp_irq();
        return (|(m_hs & m_he)) | ((|(m_ds & m_de)) & m_g);
    endfunction

    function automatic logic exp_err();
        return (|(m_hs & m_he & 4'b1011)) | (|(m_ds & m_de & 9'h1FC));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Compare every register and both outputs with the model
    task automatic check_all(input string req);
        logic [31:0] d;
        rd(12'h000, d); chk({req, " R2 hash status"}, d, {28'd0, m_hs});
        rd(12'h004, d); chk({req, " R6 hash enable"}, d, {28'd0, m_he});
        rd(12'h010, d); chk({req, " R3 dma status"}, d, {23'd0, m_ds});
        rd(12'h014, d); chk({req, " R6 dma enable"}, d, {23'd0, m_de});
        rd(12'h018, d); chk({req, " R6 gate"}, d, {31'd0, m_g});
        rd(12'h020, d); chk({req, " R9 unmapped"}, d, 32'd0);
        chk({req, " R7 irq"}, {31'd0, irq}, {31'd0, exp_irq()});
        chk({req, " R8 irq_err"}, {31'd0, irq_err}, {31'd0, exp_err()});
    endtask

    // One clock: drive at negedge, update the model after the edge
    task automatic step(input logic we, input logic [11:0] a, input logic [31:0] wd,
                        input logic [3:0] he, input logic [8:0] de);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd; hash_evt = he; dma_evt = de;
        @(posedge clk);
        #1;
        m_hs = ((m_hs & ~((we && a == 12'h000) ? wd[3:0] : 4'h0)) | he);
        m_ds = ((m_ds & ~((we && a == 12'h010) ? wd[8:0] : 9'h0)) | de) & 9'h1FD;
        if (we && a == 12'h004) m_he = wd[3:0];
        if (we && a == 12'h014) m_de = wd[8:0] & 9'h1FD;
        if (we && a == 12'h018) m_g = wd[0];
        reg_we = 0; hash_evt = '0; dma_evt = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] addrs [6];
        void'($urandom(32'd1234));
        addrs = '{12'h000, 12'h004, 12'h010, 12'h014, 12'h018, 12'h020};
        m_hs = '0; m_he = '0; m_ds = '0; m_de = '0; m_g = 0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R3: unimplemented DMA bit 1
        step(1, 12'h014, 32'h1FF, 4'h0, 9'h002);
        check_all("R3 bit1");
        // R6: hash enable zero keeps hash bank quiet
        step(0, 12'h020, 32'h0, 4'hF, 9'h0);
        check_all("R6 zero enable");
        // R8: DMA error with gate closed
        step(0, 12'h020, 32'h0, 4'h0, 9'h004);
        check_all("R8 gate closed err");
        // R7: open the gate
        step(1, 12'h018, 32'h1, 4'h0, 9'h0);
        check_all("R7 gate open");
        // R5: event collides with clear of same bit
        step(1, 12'h010, 32'hFFFF_FFFF, 4'h0, 9'h004);
        check_all("R5 collision");
        // R4: all ones clears everything
        step(1, 12'h000, 32'hFFFF_FFFF, 4'h0, 9'h0);
        step(1, 12'h010, 32'hFFFF_FFFF, 4'h0, 9'h0);
        check_all("R4 clear all");
        // R9: write to unmapped leaves state
        step(1, 12'h024, 32'hFFFF_FFFF, 4'h0, 9'h0);
        check_all("R9 unmapped write");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] wd;
            logic [3:0]  he;
            logic [8:0]  de;
            wd = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
            he = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0;
            de = ($urandom_range(0, 2) == 0) ? 9'($urandom) : 9'h0;
            step($urandom_range(0, 1) == 1, addrs[$urandom_range(0, 5)], wd, he, de);
            check_all("random R2 R4 R7");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule